// File: doc/BRIEF.md
# Vector-Table Event Transfer Engine

This block moves one data item per activation on behalf of a peripheral or of software, without CPU involvement in the copy itself. An activation comes either from one of several hardware request lines, each gated by its own enable bit, or from a software trigger that carries an 8-bit vector number. The engine reads a vector table entry, adds it to a base address to find a three-word descriptor in memory, loads the descriptor, performs one read and one write of the configured item size, then stores the updated count and addresses back into the descriptor.

Descriptor layout, relative to its address D: word D+0 holds the count in bits 31:16 and the mode in bits 15:0; D+4 holds the source address; D+8 holds the destination address. A linked descriptor, when used, sits at D+12. The vector table entry for vector v is the 32-bit word at `VT_ADDR + 4*v`. Only its low 16 bits are used. Hardware source i uses vector i. Mode bits: bit 0 is the source step (0 fixed, 1 increment); bits 2:1 are the destination step (10 increment, 11 decrement, otherwise fixed); bits 4:3 are the transfer mode (00 normal); bits 6:5 are the size (00 byte, 01 halfword, 10 or 11 word); bit 7 is the link bit; bit 8 is the interrupt select.

When an activation finishes, the engine decides whether to request a CPU interrupt. Without an interrupt it retires the request: it pulses the source clear, or it drops the software trigger. With an interrupt it leaves the request pending and withdraws its own permission instead: it clears the hardware enable bit, or it keeps the software trigger set but marks it served.

Top module: `irq_xfer_ctrl`

## Requirements
- R1: A hardware request whose enable bit is 0 starts no activation: `busy` stays 0 and no bus access is made.
- R2: The first bus access of an activation reads `VT_ADDR + 4*vector`. The descriptor is then read at `base_addr` plus the low 16 bits of that entry.
- R3: A hardware activation that ends without an interrupt pulses `src_clr` for that source for one cycle and leaves its enable bit at 1.
- R4: A hardware activation that ends with an interrupt pulses `cpu_irq` with the vector on `cpu_irq_vec`, does not pulse `src_clr`, and clears that source's enable bit.
- R5: `sw_wr` is accepted only while `sw_pend` is 0, and it then latches `sw_vec`. A write while `sw_pend` is 1 is ignored.
- R6: A software activation clears `sw_pend` when no interrupt is raised. With an interrupt, `sw_pend` stays 1 and the activation does not repeat until `sw_clr`.
- R7: With interrupt select 0, an interrupt is raised only when the decremented count is zero. With interrupt select 1, one is raised after every activation.
- R8: The count drops by one. An address in increment or decrement mode moves by 1, 2 or 4 for byte, halfword or word size. A fixed address is unchanged.
- R9: The updated count (with the mode), source and destination are written back to D+0, D+4 and D+8 before `busy` falls. A bus request holds its address until it is acknowledged.
- R10: Among simultaneous requests, enabled hardware sources win over software, and the lowest source index wins among them.
- R11: `busy` is 1 from the start of an activation until the engine is idle again, and covers every bus access.
- R12: With the link bit set in the first descriptor, a second descriptor at D+12 is processed in the same activation. The interrupt decision comes from that second descriptor.
- R13: The data write stores exactly 1, 2 or 4 bytes according to the size field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | NSRC | Pending hardware request per source |
| en_wr | input | 1 | Load the enable bits from `en_wdata` |
| en_wdata | input | NSRC | New enable bit values |
| en_q | output | NSRC | Current enable bits |
| sw_wr | input | 1 | Software trigger write |
| sw_vec | input | 8 | Vector number carried by the software trigger |
| sw_clr | input | 1 | Clears the software trigger |
| sw_pend | output | 1 | Software trigger bit |
| base_addr | input | 32 | Descriptor base address |
| mem_req | output | 1 | Bus request, held until acknowledged |
| mem_we | output | 1 | Bus write |
| mem_addr | output | 32 | Bus byte address |
| mem_size | output | 2 | Access size: 00 byte, 01 halfword, 10 word |
| mem_wdata | output | 32 | Write data, low-aligned |
| mem_rdata | input | 32 | Read data, low-aligned, valid with `mem_ack` |
| mem_ack | input | 1 | Access completion |
| src_clr | output | NSRC | One-cycle clear of a hardware source |
| cpu_irq | output | 1 | One-cycle CPU interrupt request |
| cpu_irq_vec | output | 8 | Vector belonging to `cpu_irq` |
| busy | output | 1 | Activation in progress |

## Verification
The bench builds the engine with four hardware sources and the vector table at 0x100. With four sources, a priority contest among sources 1 and 3 and a software trigger is possible within one cycle, and the highest source index is exercised. The small table offset keeps every vector, descriptor and data buffer in a sparse memory model. The memory acknowledges every access after one wait cycle, so each handshake holds its request across an edge. The runs cover all three item sizes, both destination directions, the count reaching zero, a linked descriptor, and software writes that collide with a pending trigger.

// File: rtl/ixc_pkg.sv
package ixc_pkg;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int VW = 8;

  localparam logic [1:0] DST_INC = 2'b10;
  localparam logic [1:0] DST_DEC = 2'b11;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [3:0] {
    ST_IDLE, ST_VEC, ST_D0, ST_D1, ST_D2,
    ST_XRD, ST_XWR, ST_W0, ST_W1, ST_W2, ST_DONE
  } ixc_state_e;

  typedef struct packed {
    logic [6:0] rsvd;
    logic       isel;
    logic       link;
    logic [1:0] size;
    logic [1:0] xmode;
    logic [1:0] dstep;
    logic       sinc;
  } ixc_mode_t;
endpackage

// File: rtl/ixc_rst_sync.sv
module ixc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/ixc_trig.sv
module ixc_trig import ixc_pkg::*; #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  input  logic [NSRC-1:0] fin_en_clr,
  input  logic            sw_wr,
  input  logic [VW-1:0]   sw_vec,
  input  logic            sw_clr,
  input  logic            fin_sw_drop,
  input  logic            fin_sw_keep,
  output logic [NSRC-1:0] en_q,
  output logic            sw_pend,
  output logic            sw_armed,
  output logic [VW-1:0]   sw_vec_q
);
  logic [NSRC-1:0] en_d;
  logic            pend_d, served_q, served_d;
  logic [VW-1:0]   vec_d;

  always_comb begin
    en_d = en_q;
    if (en_wr) en_d = en_wdata;
    en_d = en_d & ~fin_en_clr;
  end

  always_comb begin
    pend_d   = sw_pend;
    served_d = served_q;
    vec_d    = sw_vec_q;
    if (sw_clr) begin
      pend_d   = 1'b0;
      served_d = 1'b0;
    end else if (fin_sw_drop) begin
      pend_d = 1'b0;
    end else if (fin_sw_keep) begin
      served_d = 1'b1;
    end else if (sw_wr && !sw_pend) begin
      pend_d = 1'b1;
      vec_d  = sw_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      sw_pend  <= 1'b0;
      served_q <= 1'b0;
      sw_vec_q <= '0;
    end else begin
      en_q     <= en_d;
      sw_pend  <= pend_d;
      served_q <= served_d;
      sw_vec_q <= vec_d;
    end
  end

  assign sw_armed = sw_pend & ~served_q;
endmodule

// File: rtl/ixc_arb.sv
module ixc_arb import ixc_pkg::*; #(
  parameter int NSRC = 8,
  parameter int IW   = 3
) (
  input  logic [NSRC-1:0] act,
  input  logic            sw_armed,
  input  logic [VW-1:0]   sw_vec,
  output logic            go,
  output logic            pick_sw,
  output logic [IW-1:0]   pick_idx,
  output logic [VW-1:0]   pick_vec
);
  logic hw_hit;

  always_comb begin
    hw_hit   = 1'b0;
    pick_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) begin
        hw_hit   = 1'b1;
        pick_idx = IW'(i);
      end
    end
    go       = hw_hit | sw_armed;
    pick_sw  = ~hw_hit & sw_armed;
    pick_vec = pick_sw ? sw_vec : VW'(pick_idx);
  end
endmodule

// File: rtl/ixc_step.sv
module ixc_step import ixc_pkg::*; (
  input  logic [1:0]    size,
  input  logic          sinc,
  input  logic [1:0]    dstep,
  input  logic          isel,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] sa,
  input  logic [AW-1:0] da,
  output logic [AW-1:0] sa_nx,
  output logic [AW-1:0] da_nx,
  output logic [CW-1:0] cnt_nx,
  output logic          irq
);
  logic [AW-1:0] stride;

  always_comb begin
    unique case (size)
      2'b00:   stride = AW'(1);
      2'b01:   stride = AW'(2);
      default: stride = AW'(4);
    endcase
    sa_nx = sinc ? sa + stride : sa;
    unique case (dstep)
      DST_INC: da_nx = da + stride;
      DST_DEC: da_nx = da - stride;
      default: da_nx = da;
    endcase
    cnt_nx = cnt - CW'(1);
    irq    = isel | (cnt_nx == '0);
  end
endmodule

// File: rtl/irq_xfer_ctrl.sv
module irq_xfer_ctrl import ixc_pkg::*; #(
  parameter int            NSRC    = 8,
  parameter logic [AW-1:0] VT_ADDR = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  output logic [NSRC-1:0] en_q,
  input  logic            sw_wr,
  input  logic [VW-1:0]   sw_vec,
  input  logic            sw_clr,
  output logic            sw_pend,
  input  logic [AW-1:0]   base_addr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_size,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  output logic [NSRC-1:0] src_clr,
  output logic            cpu_irq,
  output logic [VW-1:0]   cpu_irq_vec,
  output logic            busy
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic            rst_q_n;
  ixc_state_e      state_q, state_d;
  logic [VW-1:0]   vec_q, vec_d;
  logic            sw_q, sw_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [AW-1:0]   dptr_q, dptr_d;
  ixc_mode_t       mode_q, mode_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [AW-1:0]   sa_q, sa_d, da_q, da_d;
  logic [DW-1:0]   dat_q, dat_d;
  logic            irq_q, irq_d, link_q, link_d;

  logic            sw_armed, arb_go, arb_sw;
  logic [VW-1:0]   sw_vec_q, arb_vec;
  logic [IW-1:0]   arb_idx;
  logic [AW-1:0]   sa_nx, da_nx;
  logic [CW-1:0]   cnt_nx;
  logic            step_irq;
  logic            fin, fin_hw_keep;
  logic [NSRC-1:0] idx_hot;

  ixc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign fin         = (state_q == ST_DONE);
  assign idx_hot     = NSRC'(1) << idx_q;
  assign fin_hw_keep = fin & ~sw_q & irq_q;

  ixc_trig #(.NSRC(NSRC)) u_trig (
    .clk(clk), .rst_n(rst_q_n),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .fin_en_clr(fin_hw_keep ? idx_hot : '0),
    .sw_wr(sw_wr), .sw_vec(sw_vec), .sw_clr(sw_clr),
    .fin_sw_drop(fin & sw_q & ~irq_q),
    .fin_sw_keep(fin & sw_q & irq_q),
    .en_q(en_q), .sw_pend(sw_pend), .sw_armed(sw_armed), .sw_vec_q(sw_vec_q)
  );

  ixc_arb #(.NSRC(NSRC), .IW(IW)) u_arb (
    .act(src_req & en_q), .sw_armed(sw_armed), .sw_vec(sw_vec_q),
    .go(arb_go), .pick_sw(arb_sw), .pick_idx(arb_idx), .pick_vec(arb_vec)
  );

  ixc_step u_step (
    .size(mode_q.size), .sinc(mode_q.sinc), .dstep(mode_q.dstep),
    .isel(mode_q.isel), .cnt(cnt_q), .sa(sa_q), .da(da_q),
    .sa_nx(sa_nx), .da_nx(da_nx), .cnt_nx(cnt_nx), .irq(step_irq)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;  vec_d  = vec_q;  sw_d  = sw_q;   idx_d = idx_q;
    dptr_d  = dptr_q;   mode_d = mode_q; cnt_d = cnt_q;  sa_d  = sa_q;
    da_d    = da_q;     dat_d  = dat_q;  irq_d = irq_q;  link_d = link_q;
    unique case (state_q)
      ST_IDLE: if (arb_go) begin
        vec_d   = arb_vec;
        sw_d    = arb_sw;
        idx_d   = arb_idx;
        link_d  = 1'b0;
        state_d = ST_VEC;
      end
      ST_VEC: if (mem_ack) begin
        dptr_d  = base_addr + AW'(mem_rdata[15:0]);
        state_d = ST_D0;
      end
      ST_D0: if (mem_ack) begin
        mode_d  = ixc_mode_t'(mem_rdata[15:0]);
        cnt_d   = mem_rdata[31:16];
        state_d = ST_D1;
      end
      ST_D1: if (mem_ack) begin
        sa_d    = mem_rdata;
        state_d = ST_D2;
      end
      ST_D2: if (mem_ack) begin
        da_d    = mem_rdata;
        state_d = ST_XRD;
      end
      ST_XRD: if (mem_ack) begin
        dat_d   = mem_rdata;
        state_d = ST_XWR;
      end
      ST_XWR: if (mem_ack) begin
        sa_d    = sa_nx;
        da_d    = da_nx;
        cnt_d   = cnt_nx;
        irq_d   = step_irq;
        state_d = ST_W0;
      end
      ST_W0: if (mem_ack) state_d = ST_W1;
      ST_W1: if (mem_ack) state_d = ST_W2;
      ST_W2: if (mem_ack) begin
        if (mode_q.link && !link_q) begin
          link_d  = 1'b1;
          dptr_d  = dptr_q + AW'(12);
          state_d = ST_D0;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE; vec_q <= '0;  sw_q  <= 1'b0; idx_q  <= '0;
      dptr_q  <= '0;      mode_q <= '0; cnt_q <= '0;   sa_q   <= '0;
      da_q    <= '0;      dat_q <= '0;  irq_q <= 1'b0; link_q <= 1'b0;
    end else begin
      state_q <= state_d; vec_q <= vec_d;   sw_q  <= sw_d;  idx_q  <= idx_d;
      dptr_q  <= dptr_d;  mode_q <= mode_d; cnt_q <= cnt_d; sa_q   <= sa_d;
      da_q    <= da_d;    dat_q <= dat_d;   irq_q <= irq_d; link_q <= link_d;
    end
  end

  // bus drive
  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = dptr_q;
    mem_size  = SZ_WORD;
    mem_wdata = '0;
    unique case (state_q)
      ST_VEC: mem_addr = VT_ADDR + AW'({vec_q, 2'b00});
      ST_D0:  mem_addr = dptr_q;
      ST_D1:  mem_addr = dptr_q + AW'(4);
      ST_D2:  mem_addr = dptr_q + AW'(8);
      ST_XRD: begin
        mem_addr = sa_q;
        mem_size = mode_q.size;
      end
      ST_XWR: begin
        mem_we    = 1'b1;
        mem_addr  = da_q;
        mem_size  = mode_q.size;
        mem_wdata = dat_q;
      end
      ST_W0: begin
        mem_we    = 1'b1;
        mem_wdata = {cnt_q, mode_q};
      end
      ST_W1: begin
        mem_we    = 1'b1;
        mem_addr  = dptr_q + AW'(4);
        mem_wdata = sa_q;
      end
      ST_W2: begin
        mem_we    = 1'b1;
        mem_addr  = dptr_q + AW'(8);
        mem_wdata = da_q;
      end
      default: mem_req = 1'b0;
    endcase
  end

  assign busy        = (state_q != ST_IDLE);
  assign cpu_irq     = fin & irq_q;
  assign cpu_irq_vec = vec_q;
  assign src_clr     = (fin & ~sw_q & ~irq_q) ? idx_hot : '0;
endmodule

// File: rtl/ixc_chk.sv
module ixc_chk import ixc_pkg::*; #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_wr,
  input logic [NSRC-1:0] en_q,
  input logic            sw_clr,
  input logic            sw_pend,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [AW-1:0]   mem_addr,
  input logic [NSRC-1:0] src_clr,
  input logic            cpu_irq,
  input logic            busy
);
  assert_bus_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_clr_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_clr));

  assert_clr_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_clr) |-> !cpu_irq);

  assert_en_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|src_clr) && !en_wr) |=> (en_q == $past(en_q)));

  assert_en_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(en_q) & ~en_q)) |-> ($past(cpu_irq) || $past(en_wr)));

  assert_sw_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_pend) |-> ($past(sw_clr) || ($past(busy) && !$past(cpu_irq))));

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> !cpu_irq);
endmodule

bind irq_xfer_ctrl ixc_chk #(.NSRC(NSRC)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_q(en_q), .sw_clr(sw_clr),
  .sw_pend(sw_pend), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .src_clr(src_clr), .cpu_irq(cpu_irq), .busy(busy)
);

// File: tb/test_irq_xfer_ctrl.sv
module test_irq_xfer_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam logic [31:0] VT = 32'h100;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam int WD = 100000;

  typedef struct packed { logic kind; logic [7:0] id; } ev_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [NS-1:0] req, raise, drop, en_wdata, en_q, src_clr;
  logic en_wr, sw_wr, sw_clr, sw_pend;
  logic [7:0] sw_vec, cpu_irq_vec;
  logic mem_req, mem_we, mem_ack, cpu_irq, busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] mem_size;
  logic [7:0] mem [int unsigned];
  ev_t expq[$];
  logic [31:0] acc_log[$];
  int total = 0, bad = 0, bus_cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_xfer_ctrl #(.NSRC(NS), .VT_ADDR(VT)) i_irq_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(req), .en_wr(en_wr), .en_wdata(en_wdata),
    .en_q(en_q), .sw_wr(sw_wr), .sw_vec(sw_vec), .sw_clr(sw_clr), .sw_pend(sw_pend),
    .base_addr(BASE), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .src_clr(src_clr), .cpu_irq(cpu_irq),
    .cpu_irq_vec(cpu_irq_vec), .busy(busy)
  );

  function automatic logic [7:0] peek8(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [31:0] peek32(input logic [31:0] a);
    return {peek8(a + 3), peek8(a + 2), peek8(a + 1), peek8(a)};
  endfunction
  task automatic poke32(input logic [31:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
  endtask

  // memory model: one wait cycle per access
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= peek32(mem_addr);
        if (mem_we) begin
          mem[mem_addr] = mem_wdata[7:0];
          if (mem_size != 2'b00) mem[mem_addr + 1] = mem_wdata[15:8];
          if (mem_size[1]) begin
            mem[mem_addr + 2] = mem_wdata[23:16];
            mem[mem_addr + 3] = mem_wdata[31:24];
          end
        end
      end
    end
  end

  // request source model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= '0;
    else        req <= (req | raise) & ~(src_clr | drop);
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic check_ev(input ev_t got);
    ev_t want;
    if (expq.size() == 0) begin
      total++; bad++;
      $display("FAIL R10 unexpected completion: actual=%h expected=none", got);
    end else begin
      want = expq.pop_front();
      chk(got.kind ? "R4 irq event" : "R3 clear event", 32'(got), 32'(want));
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) bus_cycles++;
      if (mem_req && mem_ack) acc_log.push_back(mem_addr);
      if (|src_clr) begin
        for (int i = 0; i < NS; i++)
          if (src_clr[i]) check_ev('{kind: 1'b0, id: 8'(i)});
      end
      if (cpu_irq) check_ev('{kind: 1'b1, id: cpu_irq_vec});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_en(input logic [NS-1:0] v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask
  task automatic pulse_raise(input logic [NS-1:0] m);
    @(negedge clk); raise = m;
    @(negedge clk); raise = '0;
  endtask
  task automatic pulse_drop(input logic [NS-1:0] m);
    @(negedge clk); drop = m;
    @(negedge clk); drop = '0;
  endtask
  task automatic sw_write(input logic [7:0] v);
    @(negedge clk); sw_wr = 1'b1; sw_vec = v;
    @(negedge clk); sw_wr = 1'b0;
  endtask
  task automatic sw_clear();
    @(negedge clk); sw_clr = 1'b1;
    @(negedge clk); sw_clr = 1'b0;
  endtask
  task automatic wait_idle();
    cyc(4);
    while (busy) @(negedge clk);
    cyc(2);
  endtask
  task automatic push_ev(input logic k, input logic [7:0] id);
    expq.push_back('{kind: k, id: id});
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog: busy=%0b expected=0", busy);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bc;
    rst_n = 1'b0; raise = '0; drop = '0; en_wr = 1'b0; en_wdata = '0;
    sw_wr = 1'b0; sw_vec = '0; sw_clr = 1'b0;
    // vector table entries
    poke32(VT + 0,  32'h0200); poke32(VT + 4,  32'h02C0);
    poke32(VT + 8,  32'h0230); poke32(VT + 12, 32'h02F0);
    poke32(VT + 20, 32'h0260); poke32(VT + 24, 32'h0290);
    poke32(VT + 28, 32'h0320);
    cyc(5); rst_n = 1'b1; cyc(4);

    chk("R11 reset busy", 32'(busy), 0);
    chk("R1 reset enables", 32'(en_q), 0);
    chk("R5 reset sw_pend", 32'(sw_pend), 0);

    // R1: disabled source is ignored
    bc = bus_cycles;
    pulse_raise(4'b0001); cyc(20);
    chk("R1 busy with enable 0", 32'(busy), 0);
    chk("R1 bus cycles with enable 0", 32'(bus_cycles - bc), 0);
    pulse_drop(4'b0001);

    // R2/R3/R8/R9: byte, fixed source, incrementing destination
    poke32(BASE + 32'h200, 32'h0003_0004);
    poke32(BASE + 32'h204, 32'h2000);
    poke32(BASE + 32'h208, 32'h3000);
    poke32(32'h2000, 32'h0000_00A5);
    set_en(4'b0001);
    acc_log.delete();
    push_ev(1'b0, 8'd0);
    pulse_raise(4'b0001); cyc(2);
    chk("R11 busy during transfer", 32'(busy), 1);
    wait_idle();
    chk("R2 vector table address", acc_log[0], VT);
    chk("R2 descriptor address", acc_log[1], BASE + 32'h200);
    chk("R3 data moved", 32'(peek8(32'h3000)), 32'hA5);
    chk("R9 count written back", peek32(BASE + 32'h200), 32'h0002_0004);
    chk("R8 fixed source", peek32(BASE + 32'h204), 32'h2000);
    chk("R8 byte destination step", peek32(BASE + 32'h208), 32'h3001);
    chk("R3 enable kept", 32'(en_q), 32'b0001);

    // R7: count 2 -> 1 no irq, then 1 -> 0 irq
    mem[32'h2000] = 8'h5A;
    push_ev(1'b0, 8'd0);
    pulse_raise(4'b0001); wait_idle();
    chk("R7 count 1 write back", peek32(BASE + 32'h200), 32'h0001_0004);
    push_ev(1'b1, 8'd0);
    pulse_raise(4'b0001); wait_idle();
    chk("R7 count zero write back", peek32(BASE + 32'h200), 32'h0000_0004);
    chk("R4 enable cleared", 32'(en_q), 0);
    chk("R4 source left pending", 32'(req[0]), 1);
    chk("R8 third destination byte", 32'(peek8(32'h3002)), 32'h5A);
    pulse_drop(4'b0001);

    // R8/R13: word, incrementing source, decrementing destination, isel 1
    poke32(BASE + 32'h230, 32'h0005_0147);
    poke32(BASE + 32'h234, 32'h4000);
    poke32(BASE + 32'h238, 32'h5000);
    poke32(32'h4000, 32'h1122_3344);
    set_en(4'b0100);
    push_ev(1'b1, 8'd2);
    pulse_raise(4'b0100); wait_idle();
    chk("R13 word moved", peek32(32'h5000), 32'h1122_3344);
    chk("R7 isel count write back", peek32(BASE + 32'h230), 32'h0004_0147);
    chk("R8 word source step", peek32(BASE + 32'h234), 32'h4004);
    chk("R8 word destination decrement", peek32(BASE + 32'h238), 32'h4FFC);
    chk("R4 enable cleared isel", 32'(en_q), 0);
    pulse_drop(4'b0100);

    // R5/R6: software trigger, second write ignored, halfword
    poke32(BASE + 32'h260, 32'h0009_0025);
    poke32(BASE + 32'h264, 32'h4100);
    poke32(BASE + 32'h268, 32'h5100);
    poke32(32'h4100, 32'h0000_BEEF);
    mem[32'h5102] = 8'h99;
    poke32(BASE + 32'h290, 32'h0007_0100);
    poke32(BASE + 32'h294, 32'h4200);
    poke32(BASE + 32'h298, 32'h5200);
    poke32(32'h4200, 32'h0000_0077);
    mem[32'h5200] = 8'h00;
    sw_write(8'd5);
    chk("R5 sw_pend set", 32'(sw_pend), 1);
    sw_write(8'd6);
    wait_idle();
    chk("R6 sw_pend cleared without irq", 32'(sw_pend), 0);
    chk("R13 halfword moved", {peek8(32'h5101), peek8(32'h5100)}, 32'hBEEF);
    chk("R13 byte beyond halfword untouched", 32'(peek8(32'h5102)), 32'h99);
    chk("R8 halfword write back", peek32(BASE + 32'h260), 32'h0008_0025);
    chk("R8 halfword source step", peek32(BASE + 32'h264), 32'h4102);
    chk("R5 ignored vector untouched", peek32(BASE + 32'h290), 32'h0007_0100);
    chk("R5 ignored vector no data", 32'(peek8(32'h5200)), 0);

    // R6: software trigger with interrupt stays set, no repeat
    push_ev(1'b1, 8'd6);
    sw_write(8'd6); wait_idle(); cyc(40);
    chk("R6 sw_pend kept with irq", 32'(sw_pend), 1);
    chk("R6 single activation", peek32(BASE + 32'h290), 32'h0006_0100);
    chk("R6 data moved", 32'(peek8(32'h5200)), 32'h77);
    chk("R6 idle after", 32'(busy), 0);
    sw_clear();
    chk("R6 sw_clr", 32'(sw_pend), 0);

    // R10: sources 1 and 3 plus software at once
    poke32(BASE + 32'h2C0, 32'h0002_0100);
    poke32(BASE + 32'h2C4, 32'h4300); poke32(BASE + 32'h2C8, 32'h5300);
    poke32(BASE + 32'h2F0, 32'h0002_0100);
    poke32(BASE + 32'h2F4, 32'h4301); poke32(BASE + 32'h2F8, 32'h5301);
    poke32(BASE + 32'h320, 32'h0002_0100);
    poke32(BASE + 32'h324, 32'h4302); poke32(BASE + 32'h328, 32'h5302);
    set_en(4'b1010);
    push_ev(1'b1, 8'd1); push_ev(1'b1, 8'd3); push_ev(1'b1, 8'd7);
    @(negedge clk); raise = 4'b1010; sw_wr = 1'b1; sw_vec = 8'd7;
    @(negedge clk); raise = '0; sw_wr = 1'b0;
    cyc(200);
    chk("R10 all served in order", 32'(expq.size()), 0);
    chk("R10 enables cleared", 32'(en_q), 0);
    chk("R10 sw served last", 32'(sw_pend), 1);
    pulse_drop(4'b1010); sw_clear();

    // R12: linked descriptor, decision from the link
    poke32(BASE + 32'h200, 32'h000A_0084);
    poke32(BASE + 32'h204, 32'h6000); poke32(BASE + 32'h208, 32'h7000);
    poke32(BASE + 32'h20C, 32'h0001_0004);
    poke32(BASE + 32'h210, 32'h6100); poke32(BASE + 32'h214, 32'h7100);
    poke32(32'h6000, 32'h3C); poke32(32'h6100, 32'hC3);
    set_en(4'b0001);
    push_ev(1'b1, 8'd0);
    pulse_raise(4'b0001); wait_idle();
    chk("R12 first item", 32'(peek8(32'h7000)), 32'h3C);
    chk("R12 linked item", 32'(peek8(32'h7100)), 32'hC3);
    chk("R12 first write back", peek32(BASE + 32'h200), 32'h0009_0084);
    chk("R12 link write back", peek32(BASE + 32'h20C), 32'h0000_0004);
    chk("R12 link destination", peek32(BASE + 32'h214), 32'h7101);
    chk("R12 enable cleared by link irq", 32'(en_q), 0);
    pulse_drop(4'b0001);
    cyc(5);
    chk("R10 no leftover events", 32'(expq.size()), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule